// File: doc/BRIEF.md
# Fractional Open-Circuit MPP Input Regulator

This block keeps an energy harvester near its maximum power point. At fixed intervals it opens a switch that disconnects the source from the converter input. It waits a settle time for the source to reach its open-circuit voltage, then captures the source-voltage code. From that code it derives a target input voltage, which is a pin-selected fraction of the open-circuit value, either 80 % or 90 %. Between samples it gates the boost converter on and off with a hysteretic comparison of the live source voltage against the held target. It is not a perturb-and-observe search.

All voltages are unsigned codes with 1 LSB = 1 mV and a default width of 12 bits. A timebase tick paces the sampling schedule. A permit signal from the charge sequencer can force the boost converter off, for example during cold start or top-voltage operation. Analog sensing and the power stage sit outside the block.

Top module: `mpp_input_regulator`

## Requirements
- R1: After reset, `src_open` is 0, `boost_run` is 0 and `target_code` is 100 (the lower clamp).
- R2: While regulating, `src_open` rises on the PERIOD_TICKS-th tick counted since reset or since the previous sample closed.
- R3: `src_open` stays high for exactly SETTLE_TICKS ticks. `vsrc_code` is captured on the tick that closes the switch.
- R4: With `ratio_hi` = 1 at the capture, the unclamped target is (x*461 + 256) >> 9, where x is the captured code (about 90 %).
- R5: With `ratio_hi` = 0 at the capture, the unclamped target is (x*205 + 128) >> 8 (about 80 %).
- R6: The stored target is clamped to the range 100 to 1300 inclusive, so it always lies in that range.
- R7: `boost_run` becomes 1 on the next edge when `vsrc_code` > target + 25, provided permit is high and no sample is starting or in progress.
- R8: `boost_run` becomes 0 on the next edge when `vsrc_code` < target − 25.
- R9: While `vsrc_code` lies within target ± 25 inclusive, `boost_run` keeps its previous value.
- R10: `boost_run` is 0 on the edge after any cycle in which `boost_permit` is 0.
- R11: `boost_run` is 0 in every cycle in which `src_open` is 1.
- R12: `target_code` changes only on the edge that closes the switch. Without ticks, no sample is taken and the target holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse that advances the sampling schedule |
| vsrc_code | input | CODE_W | Source-voltage code, 1 LSB = 1 mV |
| ratio_hi | input | 1 | 1 selects the 90 % fraction, 0 selects 80 % |
| boost_permit | input | 1 | Sequencer permit; 0 forces the boost off |
| src_open | output | 1 | 1 opens the source-disconnect switch |
| boost_run | output | 1 | Boost converter enable |
| target_code | output | CODE_W | Held target input voltage code |

## Verification
Every output is a register, so each result is due on the first clock edge after the input that causes it. The switch opens after PERIOD_TICKS ticks, and the target is updated on the same edge that closes the switch after SETTLE_TICKS ticks. The bench drives inputs on the falling edge and reads outputs on the following falling edge. It counts those edges to check the open and settle intervals exactly. A small configuration is used so that every input code is captured under both ratios. A full sweep of the source voltage, rising and then falling, is checked against a bench model of the hysteresis band.

// File: rtl/mppr_pkg.sv
package mppr_pkg;
    typedef enum logic {
        PH_REGULATE = 1'b0,
        PH_SETTLE   = 1'b1
    } phase_e;
endpackage

// File: rtl/mppr_timer.sv
module mppr_timer
    import mppr_pkg::*;
#(
    parameter int PERIOD_TICKS = 256,
    parameter int SETTLE_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic open_sw,
    output logic open_next,
    output logic latch_en
);
    localparam int PW = $clog2(PERIOD_TICKS + 1);
    localparam int SW = $clog2(SETTLE_TICKS + 1);
    localparam logic [PW-1:0] P_LAST = PW'(PERIOD_TICKS - 1);
    localparam logic [SW-1:0] S_LAST = SW'(SETTLE_TICKS - 1);

    typedef struct packed {
        phase_e          phase;
        logic [PW-1:0]   pcnt;
        logic [SW-1:0]   scnt;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        latch_en = 1'b0;
        if (tick) begin
            case (st_q.phase)
                PH_REGULATE: begin
                    if (st_q.pcnt == P_LAST) begin
                        st_d.phase = PH_SETTLE;
                        st_d.pcnt  = '0;
                        st_d.scnt  = '0;
                    end else begin
                        st_d.pcnt = st_q.pcnt + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (st_q.scnt == S_LAST) begin
                        st_d.phase = PH_REGULATE;
                        st_d.scnt  = '0;
                        latch_en   = 1'b1;
                    end else begin
                        st_d.scnt = st_q.scnt + 1'b1;
                    end
                end
                default: st_d.phase = PH_REGULATE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_REGULATE, pcnt: '0, scnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign open_sw   = (st_q.phase == PH_SETTLE);
    assign open_next = (st_d.phase == PH_SETTLE);

    assert_settle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        open_sw |-> (st_q.scnt < SW'(SETTLE_TICKS)));
    assert_close_after_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> !open_sw);
    assert_open_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_sw && !tick) |=> !open_sw);
endmodule

// File: rtl/mppr_fraction.sv
module mppr_fraction #(
    parameter int CODE_W   = 12,
    parameter int MIN_CODE = 100,
    parameter int MAX_CODE = 1300
) (
    input  logic [CODE_W-1:0] code,
    input  logic              ratio_hi,
    output logic [CODE_W-1:0] target
);
    localparam int XW = CODE_W + 10;
    localparam logic [CODE_W-1:0] LO = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] HI = CODE_W'(MAX_CODE);

    logic [XW-1:0]     xe, p80, p90;
    logic [CODE_W-1:0] f80, f90, raw;

    always_comb begin
        xe  = XW'(code);
        // 205/256 ~ 0.8008 : 128+64+8+4+1
        p80 = (xe << 7) + (xe << 6) + (xe << 3) + (xe << 2) + xe + XW'(128);
        // 461/512 ~ 0.9004 : 256+128+64+8+4+1
        p90 = (xe << 8) + (xe << 7) + (xe << 6) + (xe << 3) + (xe << 2) + xe + XW'(256);
        f80 = CODE_W'(p80 >> 8);
        f90 = CODE_W'(p90 >> 9);
        raw = ratio_hi ? f90 : f80;
        if (raw < LO)      target = LO;
        else if (raw > HI) target = HI;
        else               target = raw;
    end
endmodule

// File: rtl/mppr_hysteresis.sv
module mppr_hysteresis #(
    parameter int CODE_W    = 12,
    parameter int HYST_CODE = 25
) (
    input  logic [CODE_W-1:0] vsrc,
    input  logic [CODE_W-1:0] target,
    input  logic              run_q,
    input  logic              permit,
    input  logic              sampling_next,
    output logic              run_next,
    output logic              above_band,
    output logic              below_band
);
    localparam logic [CODE_W:0] H = (CODE_W+1)'(HYST_CODE);

    logic [CODE_W:0] v_ext, t_ext;

    always_comb begin
        v_ext      = {1'b0, vsrc};
        t_ext      = {1'b0, target};
        above_band = v_ext > (t_ext + H);
        below_band = (v_ext + H) < t_ext;
        run_next   = permit && !sampling_next && (above_band || (run_q && !below_band));
    end
endmodule

// File: rtl/mpp_input_regulator.sv
module mpp_input_regulator #(
    parameter int CODE_W       = 12,
    parameter int PERIOD_TICKS = 256,
    parameter int SETTLE_TICKS = 8,
    parameter int MIN_CODE     = 100,
    parameter int MAX_CODE     = 1300,
    parameter int HYST_CODE    = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] vsrc_code,
    input  logic              ratio_hi,
    input  logic              boost_permit,
    output logic              src_open,
    output logic              boost_run,
    output logic [CODE_W-1:0] target_code
);
    typedef struct packed {
        logic              run;
        logic [CODE_W-1:0] target;
    } reg_t;

    reg_t r_d, r_q;

    logic              open_next, latch_en, run_next, above_band, below_band;
    logic [CODE_W-1:0] new_target;

    mppr_timer #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .SETTLE_TICKS(SETTLE_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .open_sw  (src_open),
        .open_next(open_next),
        .latch_en (latch_en)
    );

    mppr_fraction #(
        .CODE_W  (CODE_W),
        .MIN_CODE(MIN_CODE),
        .MAX_CODE(MAX_CODE)
    ) u_fraction (
        .code    (vsrc_code),
        .ratio_hi(ratio_hi),
        .target  (new_target)
    );

    mppr_hysteresis #(
        .CODE_W   (CODE_W),
        .HYST_CODE(HYST_CODE)
    ) u_hyst (
        .vsrc         (vsrc_code),
        .target       (r_q.target),
        .run_q        (r_q.run),
        .permit       (boost_permit),
        .sampling_next(open_next),
        .run_next     (run_next),
        .above_band   (above_band),
        .below_band   (below_band)
    );

    always_comb begin
        r_d        = r_q;
        r_d.run    = run_next;
        if (latch_en) r_d.target = new_target;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{run: 1'b0, target: CODE_W'(MIN_CODE)};
        end else begin
            r_q <= r_d;
        end
    end

    assign boost_run   = r_q.run;
    assign target_code = r_q.target;

    assert_open_blocks_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        src_open |-> !boost_run);
    assert_permit_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !boost_permit |=> !boost_run);
    assert_target_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (target_code >= CODE_W'(MIN_CODE)) && (target_code <= CODE_W'(MAX_CODE)));
    assert_target_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_open && !open_next) |=> $stable(target_code));
    assert_turn_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_permit && above_band && !open_next) |=> boost_run);
    assert_turn_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        below_band |=> !boost_run);
endmodule

// File: tb/test_mpp_input_regulator.sv
module test_mpp_input_regulator;
    localparam int CW = 12;
    localparam int PER = 4;
    localparam int SET = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] vsrc = '0;
    logic          ratio_hi = 1'b0;
    logic          permit = 1'b0;
    logic          src_open, boost_run;
    logic [CW-1:0] target;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    mpp_input_regulator #(
        .CODE_W(CW), .PERIOD_TICKS(PER), .SETTLE_TICKS(SET),
        .MIN_CODE(100), .MAX_CODE(1300), .HYST_CODE(25)
    ) i_mpp_input_regulator (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vsrc_code(vsrc),
        .ratio_hi(ratio_hi), .boost_permit(permit),
        .src_open(src_open), .boost_run(boost_run), .target_code(target)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_target(input int x, input bit hi);
        int t;
        t = hi ? ((x * 461 + 256) >> 9) : ((x * 205 + 128) >> 8);
        if (t < 100) t = 100;
        if (t > 1300) t = 1300;
        return t;
    endfunction

    task automatic do_sample(input int x, input bit hi);
        int n = 0;
        int m = 0;
        int raw;
        ratio_hi = hi;
        tick = 1'b1;
        while (!src_open && n < 20) begin
            step();
            n++;
        end
        check("R2 period ticks", n, PER);
        vsrc = CW'(x);
        while (src_open && m < 20) begin
            check("R11 run low while open", int'(boost_run), 0);
            step();
            m++;
        end
        check("R3 settle ticks", m, SET);
        raw = hi ? ((x * 461 + 256) >> 9) : ((x * 205 + 128) >> 8);
        if (raw < 100 || raw > 1300)
            check("R6 clamped target", int'(target), exp_target(x, hi));
        else if (hi)
            check("R4 90pct target", int'(target), exp_target(x, hi));
        else
            check("R5 80pct target", int'(target), exp_target(x, hi));
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset open", int'(src_open), 0);
        check("R1 reset run", int'(boost_run), 0);
        check("R1 reset target", int'(target), 100);
        rst_n = 1'b1;
        permit = 1'b1;

        // exhaustive capture sweep for both ratios
        for (int r = 0; r < 2; r++) begin
            for (int x = 0; x < (1 << CW); x++) begin
                vsrc = 12'd4000;
                do_sample(x, r[0]);
            end
        end

        // set target 900 and freeze the schedule
        vsrc = '0;
        do_sample(1000, 1'b1);
        tick = 1'b0;
        check("R4 target 900", int'(target), 900);

        begin
            bit model = 0;
            for (int pass = 0; pass < 2; pass++) begin
                for (int k = 0; k <= 1400; k++) begin
                    int v = (pass == 0) ? k : 1400 - k;
                    vsrc = CW'(v);
                    step();
                    if (v > 925) begin
                        model = 1;
                        check("R7 turn on above band", int'(boost_run), 1);
                    end else if (v < 875) begin
                        model = 0;
                        check("R8 turn off below band", int'(boost_run), 0);
                    end else begin
                        check("R9 hold inside band", int'(boost_run), int'(model));
                    end
                    check("R12 target held without ticks", int'(target), 900);
                    check("R12 switch stays closed", int'(src_open), 0);
                end
            end
        end

        vsrc = 12'd1400;
        step();
        check("R7 run on", int'(boost_run), 1);
        permit = 1'b0;
        step();
        check("R10 permit low forces off", int'(boost_run), 0);
        step();
        check("R10 permit still low", int'(boost_run), 0);
        permit = 1'b1;
        step();
        check("R7 run resumes", int'(boost_run), 1);
        vsrc = 12'd900;
        step();
        check("R9 hold high inside band", int'(boost_run), 1);

        // a new sample replaces the target
        do_sample(300, 1'b0);
        check("R5 target after resample", int'(target), 240);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule